// File: doc/BRIEF.md
# Multi-format PCM slot transmitter

This block puts up to eight parallel PCM channel words onto one serial audio data line as a bus target. The bit clock and frame sync come from outside and are oversampled by the block's own system clock. Three framings are available: TDM, I2S and left-justified. The word length can be 16, 20, 24 or 32 bits, and each slot is exactly one word wide.

Each channel is given a slot number. A bit-clock offset can delay the first data bit of every frame, or of every half-frame. The polarity of the bit clock and of the frame sync can each be inverted. A separate output enable marks the bit positions that this block drives, so other devices can share the same data line.

Configuration inputs are treated as static while the block is out of reset. The channel words are sampled once per frame, at the frame start.

Top module: `pcm_slot_tx`

## Requirements
- R1: After reset, `sd_oe` and `sd_out` are 0. They stay 0 until the first frame start is seen, whatever bit-clock activity occurs before it.
- R2: `cfg_format` selects the framing:
  - 00 is TDM.
  - 01 is I2S.
  - 10 is left-justified.
  - 11 behaves exactly like TDM.
  - A frame only begins on a detected launching bit-clock edge.
- R3: `cfg_word_len` selects the word length L: 00 gives 16 bits, 01 gives 20, 10 gives 24 and 11 gives 32. Each slot is L bit positions wide. The word is sent MSB first as bits 31 down to 32-L of the channel's 32-bit word in `ch_data`; channel c occupies bits [32c+31:32c].
- R4: TDM frame layout:
  - The frame starts at the launching edge where the effective frame sync is first seen high.
  - Frame bit position p, counted from 0 at that edge, carries bit (p-offset) mod L of slot (p-offset) div L.
  - Slot numbers run up to 31. Positions past slot 31 are not driven.
- R5: I2S and left-justified frame layout:
  - An I2S frame starts where the effective frame sync is seen falling. Its left half lasts while that sync is low, and its data is delayed by one bit.
  - A left-justified frame starts where the sync is seen rising. Its left half lasts while the sync is high, and it has no delay.
  - The opposite sync edge restarts the bit count for the right half.
  - Slot numbers 0 to 15 address left-half slots 0 to 15. Numbers 16 to 31 address right-half slots 0 to 15.
  - Half-slots 16 and above are not driven.
- R6: `cfg_offset` (0 to 31) delays the first data bit of every frame, and in I2S/LJ of every half, by that many bit clocks.
- R7: On every bit position not covered by a channel's slot, `sd_oe` is 0 and `sd_out` is 0.
- R8: Each channel's 5-bit slot number sits at `cfg_slot` bits [5c+4:5c]. When several channels name the same slot, the lowest-numbered channel is sent.
- R9: Polarity controls:
  - When `cfg_bclk_inv` is 0, data launches on the falling edge of `bclk_in`. When it is 1, data launches on the rising edge.
  - When `cfg_fsync_inv` is 1, the level of `fsync_in` is inverted before any edge detection.
- R10: All channel words are captured at the frame start. Changes to `ch_data` later in the frame, including during the right half, only affect the next frame.
- R11: The frame sync can be a one-bit pulse or a square wave. In TDM only its rising (effective) edge has any meaning.
- R12: Output timing:
  - `sd_out` and `sd_oe` change only in the system-clock cycle that follows a detected launching edge, which is three system clocks after the `bclk_in` transition.
  - Each bit-clock phase lasts at least four system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | External bit clock |
| fsync_in | input | 1 | External frame sync |
| cfg_format | input | 2 | Framing select |
| cfg_word_len | input | 2 | Word length select |
| cfg_offset | input | 5 | Slot-start offset in bit clocks |
| cfg_bclk_inv | input | 1 | Bit-clock polarity inversion |
| cfg_fsync_inv | input | 1 | Frame-sync polarity inversion |
| cfg_slot | input | 40 | Eight 5-bit slot numbers |
| ch_data | input | 256 | Eight 32-bit PCM channel words |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Drive enable for the shared data line |

## Verification
Each bit that the bench launches settles three system clocks after the bench moves `bclk_in`: two synchronizer stages, then the output register. The bench therefore samples `sd_out` and `sd_oe` four system clocks after the launching transition, on the falling system-clock edge just before it drives the capturing bit-clock edge.

The expected value for every bit position of every frame is worked out from the frame position, format, offset, word length and slot table. The bench uses channel words it snapshotted at its own frame start, so a mid-frame data change is judged against the old words.

// File: rtl/pcm_slot_tx_pkg.sv
package pcm_slot_tx_pkg;

  typedef enum logic [1:0] {
    FMT_TDM = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

  // word-length code to bit count
  function automatic logic [5:0] word_bits(input logic [1:0] code);
    logic [5:0] n;
    case (code)
      2'b00:   n = 6'd16;
      2'b01:   n = 6'd20;
      2'b10:   n = 6'd24;
      default: n = 6'd32;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pcm_slot_tx_edge.sv
module pcm_slot_tx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fsync_in,
  input  logic bclk_inv,
  input  logic fsync_inv,
  output logic launch,
  output logic fs_lvl
);

  logic [SYNC_STAGES-1:0] bclk_sync_q, bclk_sync_d;
  logic [SYNC_STAGES-1:0] fs_sync_q, fs_sync_d;
  logic                   bclk_hist_q, bclk_hist_d;
  logic                   bclk_eff;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb begin
        bclk_sync_d = bclk_in;
        fs_sync_d   = fsync_in;
      end
    end else begin : g_chain
      always_comb begin
        bclk_sync_d = {bclk_sync_q[SYNC_STAGES-2:0], bclk_in};
        fs_sync_d   = {fs_sync_q[SYNC_STAGES-2:0], fsync_in};
      end
    end
  endgenerate

  always_comb begin
    bclk_eff    = bclk_sync_q[SYNC_STAGES-1] ^ bclk_inv;
    bclk_hist_d = bclk_eff;
    launch      = bclk_hist_q & ~bclk_eff;
    fs_lvl      = fs_sync_q[SYNC_STAGES-1] ^ fsync_inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sync_q <= '0;
      fs_sync_q   <= '0;
      bclk_hist_q <= 1'b0;
    end else begin
      bclk_sync_q <= bclk_sync_d;
      fs_sync_q   <= fs_sync_d;
      bclk_hist_q <= bclk_hist_d;
    end
  end

endmodule

// File: rtl/pcm_slot_tx_pos.sv
module pcm_slot_tx_pos
  import pcm_slot_tx_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int OFS_W  = 5,
  parameter int BIT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              fs_lvl,
  input  logic [1:0]        fmt_code,
  input  logic [1:0]        wlen_code,
  input  logic [OFS_W-1:0]  offset,
  output logic              nxt_live,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [BIT_W-1:0]  nxt_bit,
  output logic              start_now,
  output logic              frame_seen
);

  localparam int CNT_W  = SLOT_W + 1;
  localparam int LEAD_W = OFS_W + 1;

  logic              fs_prev_q, fs_prev_d;
  logic              seen_q, seen_d;
  logic              half_q, half_d;
  logic [LEAD_W-1:0] lead_q, lead_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [CNT_W-1:0]  slot_q, slot_d;

  fmt_e              fmt;
  logic              is_i2s, is_tdm;
  logic              fs_rise, fs_fall, frm_edge, half_edge;
  logic [LEAD_W-1:0] skip;
  logic [BIT_W-1:0]  wl_last;

  always_comb begin
    fmt       = fmt_e'(fmt_code);
    is_i2s    = (fmt == FMT_I2S);
    is_tdm    = !(is_i2s || fmt == FMT_LJ);
    fs_rise   = fs_lvl & ~fs_prev_q;
    fs_fall   = ~fs_lvl & fs_prev_q;
    frm_edge  = is_i2s ? fs_fall : fs_rise;
    half_edge = !is_tdm && seen_q && (is_i2s ? fs_rise : fs_fall);
    skip      = LEAD_W'(offset) + LEAD_W'(is_i2s);
    wl_last   = BIT_W'(word_bits(wlen_code) - 6'd1);

    fs_prev_d = fs_prev_q;
    seen_d    = seen_q;
    half_d    = half_q;
    lead_d    = lead_q;
    bit_d     = bit_q;
    slot_d    = slot_q;

    if (launch) begin
      fs_prev_d = fs_lvl;
      if (frm_edge || half_edge) begin
        seen_d = 1'b1;
        half_d = half_edge;
        lead_d = skip;
        bit_d  = '0;
        slot_d = '0;
      end else if (lead_q != '0) begin
        lead_d = lead_q - 1'b1;
      end else if (!slot_q[SLOT_W]) begin
        if (bit_q >= wl_last) begin
          bit_d  = '0;
          slot_d = slot_q + 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end

    nxt_live   = seen_d && (lead_d == '0) && !slot_d[SLOT_W] &&
                 (is_tdm || !slot_d[SLOT_W-1]);
    nxt_slot   = is_tdm ? slot_d[SLOT_W-1:0] : {half_d, slot_d[SLOT_W-2:0]};
    nxt_bit    = bit_d;
    start_now  = launch && frm_edge;
    frame_seen = seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev_q <= 1'b0;
      seen_q    <= 1'b0;
      half_q    <= 1'b0;
      lead_q    <= '0;
      bit_q     <= '0;
      slot_q    <= {1'b1, {SLOT_W{1'b0}}};
    end else begin
      fs_prev_q <= fs_prev_d;
      seen_q    <= seen_d;
      half_q    <= half_d;
      lead_q    <= lead_d;
      bit_q     <= bit_d;
      slot_q    <= slot_d;
    end
  end

  AST_BIT_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && lead_q == '0 && !slot_q[SLOT_W]) |-> (bit_q <= wl_last)); // R3

  AST_SEEN_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seen_q) |-> $past(launch)); // R2

endmodule

// File: rtl/pcm_slot_tx_mux.sv
module pcm_slot_tx_mux #(
  parameter int NCH      = 8,
  parameter int SAMPLE_W = 32,
  parameter int SLOT_W   = 5,
  parameter int BIT_W    = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    launch,
  input  logic                    start_now,
  input  logic                    live,
  input  logic [SLOT_W-1:0]       slot,
  input  logic [BIT_W-1:0]        bitn,
  input  logic [NCH*SLOT_W-1:0]   cfg_slot,
  input  logic [NCH*SAMPLE_W-1:0] ch_data,
  output logic                    sd_out,
  output logic                    sd_oe
);

  logic [NCH-1:0] hit, win, bitv;
  logic           drive, dbit;
  logic           sd_out_q, sd_out_d, sd_oe_q, sd_oe_d;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [SAMPLE_W-1:0] shadow_q, shadow_d, word;

      always_comb begin
        shadow_d = (launch && start_now) ? ch_data[c*SAMPLE_W +: SAMPLE_W] : shadow_q;
        word     = start_now ? ch_data[c*SAMPLE_W +: SAMPLE_W] : shadow_q;
        hit[c]   = live && (cfg_slot[c*SLOT_W +: SLOT_W] == slot);
        bitv[c]  = word[BIT_W'(SAMPLE_W-1) - bitn];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= shadow_d;
      end
    end
  endgenerate

  always_comb begin
    win      = hit & (~hit + 1'b1);
    drive    = |hit;
    dbit     = |(win & bitv);
    sd_oe_d  = launch ? drive : sd_oe_q;
    sd_out_d = launch ? (drive & dbit) : sd_out_q;
    sd_out   = sd_out_q;
    sd_oe    = sd_oe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_out_q <= 1'b0;
      sd_oe_q  <= 1'b0;
    end else begin
      sd_out_q <= sd_out_d;
      sd_oe_q  <= sd_oe_d;
    end
  end

endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
  import pcm_slot_tx_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SAMPLE_W    = 32,
  parameter int SLOT_W      = 5,
  parameter int OFS_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bclk_in,
  input  logic                    fsync_in,
  input  logic [1:0]              cfg_format,
  input  logic [1:0]              cfg_word_len,
  input  logic [OFS_W-1:0]        cfg_offset,
  input  logic                    cfg_bclk_inv,
  input  logic                    cfg_fsync_inv,
  input  logic [NCH*SLOT_W-1:0]   cfg_slot,
  input  logic [NCH*SAMPLE_W-1:0] ch_data,
  output logic                    sd_out,
  output logic                    sd_oe
);

  localparam int BIT_W = $clog2(SAMPLE_W);

  logic              launch, fs_lvl;
  logic              live, start_now, frame_seen;
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bitn;

  pcm_slot_tx_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_in   (bclk_in),
    .fsync_in  (fsync_in),
    .bclk_inv  (cfg_bclk_inv),
    .fsync_inv (cfg_fsync_inv),
    .launch    (launch),
    .fs_lvl    (fs_lvl)
  );

  pcm_slot_tx_pos #(.SLOT_W(SLOT_W), .OFS_W(OFS_W), .BIT_W(BIT_W)) pos_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .fs_lvl     (fs_lvl),
    .fmt_code   (cfg_format),
    .wlen_code  (cfg_word_len),
    .offset     (cfg_offset),
    .nxt_live   (live),
    .nxt_slot   (slot),
    .nxt_bit    (bitn),
    .start_now  (start_now),
    .frame_seen (frame_seen)
  );

  pcm_slot_tx_mux #(.NCH(NCH), .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) mux_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .start_now (start_now),
    .live      (live),
    .slot      (slot),
    .bitn      (bitn),
    .cfg_slot  (cfg_slot),
    .ch_data   (ch_data),
    .sd_out    (sd_out),
    .sd_oe     (sd_oe)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(launch) |-> ($stable(sd_out) && $stable(sd_oe))); // R12

  AST_NO_DRIVE_PRE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_seen |-> !sd_oe); // R1

endmodule

// File: tb/pcm_slot_tx_tb_top.sv
module pcm_slot_tx_tb_top;

  logic         clk;
  logic         rst_n;
  logic         bclk_in, fsync_in;
  logic [1:0]   cfg_format, cfg_word_len;
  logic [4:0]   cfg_offset;
  logic         cfg_bclk_inv, cfg_fsync_inv;
  logic [39:0]  cfg_slot;
  logic [255:0] ch_data;
  logic         sd_out, sd_oe;

  int n_chk, n_err;
  int fmt, wl, off;
  bit tdm_square;
  logic [31:0] data_now [8];
  logic [31:0] data_frm [8];
  logic [4:0]  slots [8];

  pcm_slot_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fsync_in(fsync_in),
    .cfg_format(cfg_format), .cfg_word_len(cfg_word_len), .cfg_offset(cfg_offset),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_fsync_inv(cfg_fsync_inv),
    .cfg_slot(cfg_slot), .ch_data(ch_data), .sd_out(sd_out), .sd_oe(sd_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish, got running expected done");
    report();
    $finish;
  end

  task automatic push_inputs;
    for (int c = 0; c < 8; c++) begin
      cfg_slot[c*5 +: 5]  = slots[c];
      ch_data[c*32 +: 32] = data_now[c];
    end
  endtask

  function automatic bit is_tdm();
    return (fmt == 0 || fmt == 3);
  endfunction

  // expected {oe, data} at frame bit position p (h = half length for I2S/LJ)
  function automatic logic [1:0] expect_bit(int p, int h);
    int half, q, skip, k, s, b, slot, len;
    len  = (wl == 3) ? 32 : 16 + 4 * wl;
    half = (!is_tdm() && p >= h) ? 1 : 0;
    q    = half ? p - h : p;
    skip = ((fmt == 1) ? 1 : 0) + off;
    if (q < skip) return 2'b00;
    k = q - skip;
    s = k / len;
    b = k % len;
    if (is_tdm()) begin
      if (s > 31) return 2'b00;
      slot = s;
    end else begin
      if (s > 15) return 2'b00;
      slot = half * 16 + s;
    end
    for (int c = 0; c < 8; c++)
      if (int'(slots[c]) == slot) return {1'b1, data_frm[c][31-b]};
    return 2'b00;
  endfunction

  task automatic bit_cycle(input logic fs_eff, input bit chk, input logic [1:0] ex,
                           input string tag, input int p);
    @(negedge clk);
    bclk_in  = cfg_bclk_inv;
    fsync_in = fs_eff ^ cfg_fsync_inv;
    repeat (4) @(negedge clk);
    if (chk) begin
      n_chk++;
      if (sd_oe !== ex[1] || sd_out !== (ex[1] & ex[0])) begin
        n_err++;
        $display("FAIL %s fmt=%0d wl=%0d off=%0d pos=%0d: oe/d got %b/%b expected %b/%b",
                 tag, fmt, wl, off, p, sd_oe, sd_out, ex[1], ex[1] & ex[0]);
      end
    end
    bclk_in = ~cfg_bclk_inv;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_bits(input int n, input bit chk, input string tag);
    for (int i = 0; i < n; i++)
      bit_cycle((fmt == 1) ? 1'b1 : 1'b0, chk, 2'b00, tag, -1);
  endtask

  task automatic start_cfg(input int f, input int w, input int o, input bit bi, input bit fi);
    @(negedge clk);
    rst_n         = 1'b0;
    fmt           = f;
    wl            = w;
    off           = o;
    cfg_format    = 2'(f);
    cfg_word_len  = 2'(w);
    cfg_offset    = 5'(o);
    cfg_bclk_inv  = bi;
    cfg_fsync_inv = fi;
    bclk_in       = ~bi;
    fsync_in      = ((f == 1) ? 1'b1 : 1'b0) ^ fi;
    push_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_bits(2, 1'b0, "");
  endtask

  task automatic run_frame(input int n, input int h, input string tag, input int chg_at);
    logic fs;
    for (int c = 0; c < 8; c++) data_frm[c] = data_now[c];
    for (int p = 0; p < n; p++) begin
      if (p == chg_at) begin
        for (int c = 0; c < 8; c++) data_now[c] = ~data_now[c] ^ 32'h0F0F_1234;
        push_inputs();
      end
      if (is_tdm())      fs = tdm_square ? (p < n / 2) : (p == 0);
      else if (fmt == 1) fs = (p >= h);
      else               fs = (p < h);
      bit_cycle(fs, 1'b1, expect_bit(p, h), tag, p);
    end
  endtask

  task automatic map_tdm;
    slots[0] = 5'd5; slots[1] = 5'd0; slots[2] = 5'd2; slots[3] = 5'd2;
    slots[4] = 5'd9; slots[5] = 5'd4; slots[6] = 5'd31; slots[7] = 5'd3;
  endtask

  task automatic map_half;
    slots[0] = 5'd0; slots[1] = 5'd16; slots[2] = 5'd1; slots[3] = 5'd17;
    slots[4] = 5'd16; slots[5] = 5'd3; slots[6] = 5'd18; slots[7] = 5'd20;
  endtask

  initial begin
    int len, n, h;
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    bclk_in = 1'b1; fsync_in = 1'b0;
    cfg_format = '0; cfg_word_len = '0; cfg_offset = '0;
    cfg_bclk_inv = 1'b0; cfg_fsync_inv = 1'b0;
    cfg_slot = '0; ch_data = '0;
    tdm_square = 1'b0;
    for (int c = 0; c < 8; c++) data_now[c] = (32'h9E37_79B9 * 32'(c + 1)) ^ 32'h5A5A_0000;
    map_tdm();

    // R1: reset state, then bit clocks with no frame start (I2S idle sync high)
    start_cfg(1, 0, 0, 1'b0, 1'b0);
    n_chk++;
    if (sd_oe !== 1'b0 || sd_out !== 1'b0) begin
      n_err++;
      $display("FAIL R1 reset: oe/d got %b/%b expected 0/0", sd_oe, sd_out);
    end
    idle_bits(6, 1'b1, "R1 no frame yet");

    // sweep of format, word length, offset, polarities and sync shape
    for (int f = 0; f < 4; f++) begin
      for (int w = 0; w < 4; w++) begin
        for (int oi = 0; oi < 3; oi++) begin
          int o;
          o   = (oi == 0) ? 0 : ((oi == 1) ? 3 : 31);
          len = (w == 3) ? 32 : 16 + 4 * w;
          tdm_square = w[1];
          if (f == 0 || f == 3) map_tdm(); else map_half();
          start_cfg(f, w, o, w[0], (oi == 1) ^ f[0]);
          if (f == 0 || f == 3) begin
            n = 6 * len + o + 3;
            run_frame(n, 0, "R2 R3 R4 R6 R7 R8 R9 R11 R12", -1);
          end else begin
            h = 3 * len + o + ((f == 1) ? 1 : 0) + 2;
            run_frame(2 * h, h, "R2 R3 R5 R6 R7 R8 R9 R12", -1);
          end
        end
      end
    end

    // R4: TDM frame reaching slot 31 and the undriven tail past it
    tdm_square = 1'b0;
    map_tdm();
    start_cfg(0, 0, 0, 1'b0, 1'b0);
    run_frame(32 * 16 + 3, 0, "R4 slot31", -1);

    // R10: data changed mid-frame in TDM, then a following frame
    start_cfg(0, 0, 2, 1'b0, 1'b0);
    run_frame(6 * 16 + 5, 0, "R10 tdm", 40);
    run_frame(6 * 16 + 5, 0, "R10 tdm next", -1);

    // R10: data changed during the right half of an I2S frame
    map_half();
    start_cfg(1, 1, 1, 1'b1, 1'b0);
    h = 3 * 20 + 1 + 1 + 2;
    run_frame(2 * h, h, "R10 i2s", h + 3);
    run_frame(2 * h, h, "R10 i2s next", -1);

    report();
    $finish;
  end

endmodule